// File: doc/BRIEF.md
# USB Control Endpoint Status Register

This block keeps the status and control bits of the default control endpoint of a USB device controller in a single byte-wide register. The control endpoint carries both IN and OUT traffic, so the same register serves both directions. Firmware reads and writes the register through a simple byte port: a write enable, write data, and a read value that is always valid. The USB protocol engine reports events as single-cycle strobes: a received OUT packet, a sent IN packet, a finished status stage, an early end of a control transfer, and a protocol violation that caused a stall.

Each bit has its own access rule. The register has write-1 service strobes that read as zero, a plain read/write stall request, bits that firmware sets and hardware clears, bits that hardware sets and firmware clears, and a stall-sent flag that clears only when a 0 is written to it. The block outputs a one-cycle interrupt pulse, a one-cycle FIFO flush pulse, a FIFO lock level and the stall request level.

A write or event sampled at a rising clock edge appears on the read value right after that edge. The interrupt and flush pulses are high during the cycle in which the matching flag first reads 1.

Top module: `ep0_ctl_status`

## Requirements
- R1: While reset is held and after it is released, the read value is 0x00, and `irq` and `fifo_flush` are low until an event or a write arrives.
- R2: Bits 7 and 6 always read 0. Writing 1 to bit 7 clears the early-end flag (bit 4). Writing 1 to bit 6 clears the OUT-ready flag (bit 0).
- R3: Bit 5 is the stall request. Every write loads it from write-data bit 5, and `stall_req` shows its value.
- R4: `ev_setup_end` sets bit 4 (early end). `fifo_lock` is high whenever bit 4 reads 1.
- R5: `ev_pkt_rcvd` sets bit 0 (OUT ready). A write to bit 0 has no effect. Bit 0 clears only through the bit-6 strobe.
- R6: `fifo_flush` is high for exactly the one cycle in which bit 4 first changes from 0 to 1.
- R7: Writing 1 to bit 3 (last data) sets it, and writing 0 to it has no effect. `ev_status_done` or `ev_setup_end` clears bit 3, and this clear wins over a firmware set in the same cycle.
- R8: `ev_proto_stall` sets bit 2 (stall sent). Writing 0 to bit 2 clears it. Writing 1 to bit 2 has no effect.
- R9: Writing 1 to bit 1 (IN ready) sets it, and writing 0 to it has no effect. `ev_pkt_sent` clears bit 1 when it is set and counts as a completion. A firmware set in the same cycle wins, and then no completion is counted.
- R10: If a hardware set of bit 4, bit 2 or bit 0 arrives in the same cycle as a firmware clear of that bit, the bit ends up set.
- R11: `irq` is high for one cycle, in the cycle where bit 4, bit 2 or bit 0 changes from 0 to 1, or where a bit-1 completion occurred. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mcu_wr | input | 1 | Firmware write enable |
| mcu_wdata | input | 8 | Firmware write data |
| mcu_rdata | output | 8 | Register read value |
| ev_setup_end | input | 1 | Control transfer ended early |
| ev_proto_stall | input | 1 | Transaction stopped by a protocol violation |
| ev_pkt_rcvd | input | 1 | OUT packet received into the FIFO |
| ev_pkt_sent | input | 1 | IN packet sent from the FIFO |
| ev_status_done | input | 1 | Status stage of the control transfer finished |
| irq | output | 1 | Endpoint interrupt pulse |
| fifo_flush | output | 1 | FIFO flush pulse |
| fifo_lock | output | 1 | Firmware FIFO access blocked |
| stall_req | output | 1 | Answer the current control transfer with a STALL |

## Verification
The assertions are gated by the internally synchronized reset, so they assume that the engine strobes and firmware writes are quiet until that reset has released. They also treat any mix of strobes in the same cycle as legal, including strobes that a real engine would never raise together, such as a packet received in the same cycle as an early end. The stimulus holds every input idle through reset and the synchronizer delay. After that it applies directed collisions between firmware writes and hardware events on the same bit, followed by a long run where each strobe and write is drawn independently, so the overlapping cases come up often.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned NFLAG   = 6;

  localparam int unsigned B_RX    = 0;
  localparam int unsigned B_TX    = 1;
  localparam int unsigned B_SSENT = 2;
  localparam int unsigned B_LAST  = 3;
  localparam int unsigned B_EARLY = 4;
  localparam int unsigned B_STALL = 5;
  localparam int unsigned B_SVRX  = 6;
  localparam int unsigned B_SVEAR = 7;

  // 1: set wins over clear in the same cycle; 0: clear wins
  localparam logic [NFLAG-1:0] SET_WINS = 6'b110111;

  typedef struct packed {
    logic setup_end;
    logic proto_stall;
    logic pkt_rcvd;
    logic pkt_sent;
    logic status_done;
  } ep0_evt_t;

endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
  parameter bit SET_PRIO = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic d_o,
  output logic q_o
);

  logic en;
  logic nxt;
  logic q_r;

  always_comb begin
    en = set_i | clr_i;
    if (SET_PRIO) begin
      nxt = set_i ? 1'b1 : 1'b0;
    end else begin
      nxt = clr_i ? 1'b0 : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (en) begin
      q_r <= nxt;
    end
  end

  assign d_o = en ? nxt : q_r;
  assign q_o = q_r;

endmodule

// File: rtl/ep0_wr_decode.sv
module ep0_wr_decode
  import ep0_pkg::*;
(
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  ep0_evt_t         evt_i,
  input  logic [NFLAG-1:0] q_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] clr_o,
  output logic             tx_done_o
);

  logic fw_set_tx;

  always_comb begin
    fw_set_tx = wr_i & wdata_i[B_TX];

    set_o = '0;
    clr_o = '0;

    set_o[B_RX]    = evt_i.pkt_rcvd;
    clr_o[B_RX]    = wr_i & wdata_i[B_SVRX];

    set_o[B_TX]    = fw_set_tx;
    clr_o[B_TX]    = evt_i.pkt_sent;

    set_o[B_SSENT] = evt_i.proto_stall;
    clr_o[B_SSENT] = wr_i & ~wdata_i[B_SSENT];

    set_o[B_LAST]  = wr_i & wdata_i[B_LAST];
    clr_o[B_LAST]  = evt_i.status_done | evt_i.setup_end;

    set_o[B_EARLY] = evt_i.setup_end;
    clr_o[B_EARLY] = wr_i & wdata_i[B_SVEAR];

    set_o[B_STALL] = wr_i & wdata_i[B_STALL];
    clr_o[B_STALL] = wr_i & ~wdata_i[B_STALL];

    tx_done_o = evt_i.pkt_sent & q_i[B_TX] & ~fw_set_tx;
  end

endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] d_i,
  input  logic [NFLAG-1:0] q_i,
  input  logic             tx_done_i,
  output logic             irq_o,
  output logic             flush_o
);

  localparam logic [NFLAG-1:0] IRQ_SRC =
    (NFLAG'(1) << B_EARLY) | (NFLAG'(1) << B_SSENT) | (NFLAG'(1) << B_RX);

  logic [NFLAG-1:0] rise;
  logic irq_nxt;
  logic flush_nxt;
  logic irq_r;
  logic flush_r;

  always_comb begin
    rise      = d_i & ~q_i;
    irq_nxt   = (|(rise & IRQ_SRC)) | tx_done_i;
    flush_nxt = rise[B_EARLY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_r   <= 1'b0;
      flush_r <= 1'b0;
    end else begin
      irq_r   <= irq_nxt;
      flush_r <= flush_nxt;
    end
  end

  assign irq_o   = irq_r;
  assign flush_o = flush_r;

endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcu_wr,
  input  logic [7:0] mcu_wdata,
  output logic [7:0] mcu_rdata,
  input  logic       ev_setup_end,
  input  logic       ev_proto_stall,
  input  logic       ev_pkt_rcvd,
  input  logic       ev_pkt_sent,
  input  logic       ev_status_done,
  output logic       irq,
  output logic       fifo_flush,
  output logic       fifo_lock,
  output logic       stall_req
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  ep0_evt_t               evt;
  logic [NFLAG-1:0]       set_v;
  logic [NFLAG-1:0]       clr_v;
  logic [NFLAG-1:0]       flag_d;
  logic [NFLAG-1:0]       flag_q;
  logic                   tx_done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    evt.setup_end   = ev_setup_end;
    evt.proto_stall = ev_proto_stall;
    evt.pkt_rcvd    = ev_pkt_rcvd;
    evt.pkt_sent    = ev_pkt_sent;
    evt.status_done = ev_status_done;
  end

  ep0_wr_decode u_dec (
    .wr_i      (mcu_wr),
    .wdata_i   (mcu_wdata),
    .evt_i     (evt),
    .q_i       (flag_q),
    .set_o     (set_v),
    .clr_o     (clr_v),
    .tx_done_o (tx_done)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ep0_flag_cell #(
      .SET_PRIO (SET_WINS[i])
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .d_o   (flag_d[i]),
      .q_o   (flag_q[i])
    );
  end

  ep0_irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .d_i       (flag_d),
    .q_i       (flag_q),
    .tx_done_i (tx_done),
    .irq_o     (irq),
    .flush_o   (fifo_flush)
  );

  assign mcu_rdata = {{(REG_W-NFLAG){1'b0}}, flag_q};
  assign fifo_lock = flag_q[B_EARLY];
  assign stall_req = flag_q[B_STALL];

endmodule

// File: rtl/ep0_ctl_status_chk.sv
module ep0_ctl_status_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       mcu_wr,
  input logic [7:0] mcu_wdata,
  input logic [7:0] mcu_rdata,
  input logic       ev_setup_end,
  input logic       ev_proto_stall,
  input logic       ev_pkt_rcvd,
  input logic       fifo_flush
);

  AST_SVC_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    mcu_rdata[7:6] == 2'b00);                                             // R2

  AST_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_setup_end |=> mcu_rdata[4]);                                       // R10

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_pkt_rcvd |=> mcu_rdata[0]);                                        // R5

  AST_SSENT_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_proto_stall |=> mcu_rdata[2]);                                     // R8

  AST_SSENT_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    (mcu_rdata[2] && !(mcu_wr && !mcu_wdata[2])) |=> mcu_rdata[2]);       // R8

  AST_LAST_ABORT: assert property (@(posedge clk) disable iff (!rst_ok)
    ev_setup_end |=> !mcu_rdata[3]);                                      // R7

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_ok)
    fifo_flush |=> !fifo_flush);                                          // R6

  AST_FLUSH_ON_EARLY: assert property (@(posedge clk) disable iff (!rst_ok)
    fifo_flush |-> mcu_rdata[4]);                                         // R6

endmodule

bind ep0_ctl_status ep0_ctl_status_chk u_chk (
  .clk            (clk),
  .rst_ok         (rst_sync_n),
  .mcu_wr         (mcu_wr),
  .mcu_wdata      (mcu_wdata),
  .mcu_rdata      (mcu_rdata),
  .ev_setup_end   (ev_setup_end),
  .ev_proto_stall (ev_proto_stall),
  .ev_pkt_rcvd    (ev_pkt_rcvd),
  .fifo_flush     (fifo_flush)
);

// File: tb/ep0_ctl_status_bench.sv
module ep0_ctl_status_bench;

  localparam int unsigned HALF_NS  = 2;
  localparam int unsigned LIMIT_CY = 200000;

  logic       clk;
  logic       rst_n;
  logic       mcu_wr;
  logic [7:0] mcu_wdata;
  logic [7:0] mcu_rdata;
  logic       ev_setup_end;
  logic       ev_proto_stall;
  logic       ev_pkt_rcvd;
  logic       ev_pkt_sent;
  logic       ev_status_done;
  logic       irq;
  logic       fifo_flush;
  logic       fifo_lock;
  logic       stall_req;

  int unsigned n_chk;
  int unsigned n_bad;
  logic [7:0]  exp_reg;
  bit          done;

  ep0_ctl_status u_ep0_ctl_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .mcu_wr         (mcu_wr),
    .mcu_wdata      (mcu_wdata),
    .mcu_rdata      (mcu_rdata),
    .ev_setup_end   (ev_setup_end),
    .ev_proto_stall (ev_proto_stall),
    .ev_pkt_rcvd    (ev_pkt_rcvd),
    .ev_pkt_sent    (ev_pkt_sent),
    .ev_status_done (ev_status_done),
    .irq            (irq),
    .fifo_flush     (fifo_flush),
    .fifo_lock      (fifo_lock),
    .stall_req      (stall_req)
  );

  initial clk = 1'b0;
  always #(HALF_NS) clk = ~clk;

  // expected {irq, flush, next register} from the requirements
  function automatic logic [9:0] model(input logic [7:0] c, input logic wr,
                                       input logic [7:0] wd, input logic se,
                                       input logic ps, input logic rx,
                                       input logic tx, input logic sd);
    logic [7:0] n;
    logic txd;
    n = c;
    n[7:6] = 2'b00;
    if (wr) n[5] = wd[5];                                   // R3
    if (se) n[4] = 1'b1; else if (wr && wd[7]) n[4] = 1'b0; // R2 R4 R10
    if (se || sd) n[3] = 1'b0; else if (wr && wd[3]) n[3] = 1'b1; // R7
    if (ps) n[2] = 1'b1; else if (wr && !wd[2]) n[2] = 1'b0; // R8
    txd = tx && c[1] && !(wr && wd[1]);                     // R9
    if (wr && wd[1]) n[1] = 1'b1; else if (tx) n[1] = 1'b0;
    if (rx) n[0] = 1'b1; else if (wr && wd[6]) n[0] = 1'b0; // R5
    model[9] = (n[4] & ~c[4]) | (n[2] & ~c[2]) | (n[0] & ~c[0]) | txd; // R11
    model[8] = n[4] & ~c[4];                                // R6
    model[7:0] = n;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic ei, input logic ef);
    chk("R2 bits7:6",  {6'd0, mcu_rdata[7:6]}, {6'd0, exp_reg[7:6]});
    chk("R3 bit5",     {7'd0, mcu_rdata[5]},   {7'd0, exp_reg[5]});
    chk("R3 stall_req",{7'd0, stall_req},      {7'd0, exp_reg[5]});
    chk("R4 bit4",     {7'd0, mcu_rdata[4]},   {7'd0, exp_reg[4]});
    chk("R4 fifo_lock",{7'd0, fifo_lock},      {7'd0, exp_reg[4]});
    chk("R7 bit3",     {7'd0, mcu_rdata[3]},   {7'd0, exp_reg[3]});
    chk("R8 bit2",     {7'd0, mcu_rdata[2]},   {7'd0, exp_reg[2]});
    chk("R9 bit1",     {7'd0, mcu_rdata[1]},   {7'd0, exp_reg[1]});
    chk("R5 bit0",     {7'd0, mcu_rdata[0]},   {7'd0, exp_reg[0]});
    chk("R11 irq",     {7'd0, irq},            {7'd0, ei});
    chk("R6 fifo_flush",{7'd0, fifo_flush},    {7'd0, ef});
  endtask

  // drive at negedge, let one rising edge pass, sample at the next negedge
  task automatic step(input logic wr, input logic [7:0] wd, input logic se,
                      input logic ps, input logic rx, input logic tx, input logic sd);
    logic [9:0] m;
    mcu_wr = wr; mcu_wdata = wd;
    ev_setup_end = se; ev_proto_stall = ps; ev_pkt_rcvd = rx;
    ev_pkt_sent = tx; ev_status_done = sd;
    m = model(exp_reg, wr, wd, se, ps, rx, tx, sd);
    @(posedge clk);
    @(negedge clk);
    exp_reg = m[7:0];
    check_all(m[9], m[8]);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(2 * HALF_NS * LIMIT_CY);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0; exp_reg = 8'h00;
    rst_n = 1'b0; mcu_wr = 1'b0; mcu_wdata = 8'h00;
    ev_setup_end = 1'b0; ev_proto_stall = 1'b0; ev_pkt_rcvd = 1'b0;
    ev_pkt_sent = 1'b0; ev_status_done = 1'b0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 reset rdata", mcu_rdata, 8'h00);
    chk("R1 reset irq",   {7'd0, irq}, 8'h00);
    chk("R1 reset flush", {7'd0, fifo_flush}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-release rdata", mcu_rdata, 8'h00);
    idle();

    // R3 stall request load and drop
    wr(8'h20); wr(8'h00);
    // R4 R6 R11 early end, then R2 service strobe
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    wr(8'h80);
    // R7 set, hardware clear, abort beats firmware set
    wr(8'h08);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10 early end set beats the bit-7 strobe
    step(1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 early end kept", {7'd0, mcu_rdata[4]}, 8'h01);
    wr(8'h80);
    // R8 set, write 1 ignored, write 0 clears
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(8'h04); wr(8'h00);
    // R5 set, write to bit0 ignored, strobe clears; R10 collision
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    wr(8'h05); wr(8'h44);
    step(1'b1, 8'h44, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 rx kept", {7'd0, mcu_rdata[0]}, 8'h01);
    wr(8'h44);
    // R9 set, completion clears with irq, firmware set wins
    wr(8'h06); wr(8'h04);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(8'h06);
    step(1'b1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) == 0, 8'($urandom),
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
           ($urandom % 6) == 0, ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule